// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps a 64-bit free-running time base and a 32-bit down-counting decrementer. A single tick-enable input, pulsed at the time-base rate by logic outside the block, advances both: the time base gains one and the decrementer loses one on every tick cycle. Software reads and writes the time base as two 32-bit words, lower and upper. Writing one word replaces only that word. The decrementer is read and written as one 32-bit word.

The decrementer raises a sticky interrupt request when its sign bit (bit 31) goes from 0 to 1. This happens when it counts down through zero, or when software writes a value with bit 31 set while the current value has bit 31 clear. After reset the decrementer holds all ones, so no request is pending at start-up. An acknowledge input clears the request.

A build-time option selects a real-time-clock compatible variant. In that variant, reads and writes of the lower time-base word are masked with 0x3FFFFF80. All other behaviour is the same.

Top module: `timebase_decr`

## Requirements
- R1: On a cycle with `tick` high and no time-base write, the 64-bit time base `{tb_hi_rd, tb_lo_rd}` increases by exactly one, carrying from the lower word into the upper word. With `tick` low and no write, it holds its value.
- R2: A write with `tb_lo_we` replaces the lower word with `wr_data` and keeps the upper word. A write with `tb_hi_we` replaces the upper word and keeps the lower word. Both strobes together replace both words.
- R3: On a cycle with `tick` high and no decrementer write, `dec_rd` decreases by one, wrapping from 0x00000000 to 0xFFFFFFFF.
- R4: A write with `dec_we` loads `wr_data` into the decrementer. In any cycle, a write to a counter wins over `tick` for that counter. Every write becomes visible on the read ports one clock after the strobe cycle.
- R5: When the decrementer counts from 0x00000000 to 0xFFFFFFFF, `dec_irq` is high from the next cycle.
- R6: A decrementer write with bit 31 set, made while the current value has bit 31 clear, sets `dec_irq` from the next cycle. A write with bit 31 set made while bit 31 is already set does not set it.
- R7: `dec_irq` stays high until a cycle with `irq_ack` high clears it. If a new request and `irq_ack` occur in the same cycle, the request wins and `dec_irq` stays high.
- R8: After reset the time base reads 0 in both words, the decrementer reads 0xFFFFFFFF and `dec_irq` is low.
- R9: With `RTC_MODE` = 1, the value written to the lower word is ANDed with 0x3FFFFF80 and the lower-word read port shows the stored value ANDed with 0x3FFFFF80. The upper word is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base rate enable |
| tb_lo_we | input | 1 | Write strobe for the lower time-base word |
| tb_hi_we | input | 1 | Write strobe for the upper time-base word |
| dec_we | input | 1 | Write strobe for the decrementer |
| wr_data | input | 32 | Shared write data |
| irq_ack | input | 1 | Clears the pending decrementer request |
| tb_lo_rd | output | 32 | Lower time-base word (masked in RTC variant) |
| tb_hi_rd | output | 32 | Upper time-base word |
| dec_rd | output | 32 | Decrementer value |
| dec_irq | output | 1 | Sticky decrementer interrupt request |

## Verification
The bench drives the decrementer to one and to zero, then ticks it through the wrap. A design that watched for zero, or for the value after the wrap, would fire one cycle early or never. It writes negative values both while the decrementer is positive and while it is already negative. This separates a true sign-edge detector from one that reacts to any negative write. It also lands ticks on the same cycles as writes and acknowledges on the same cycles as new requests, to catch a wrong priority order. Finally, it writes 0xFFFFFFFF to the lower word and ticks, which exposes a missing carry into the upper word or a half-write that corrupts the other half.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
   localparam int unsigned TBD_HALF_W = 32;
   localparam logic [TBD_HALF_W-1:0] TBD_RTC_LO_MASK = 32'h3FFF_FF80;

   function automatic logic sign_rise(input logic old_msb, input logic new_msb);
      return !old_msb && new_msb;
   endfunction
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
   parameter int unsigned HALF_W = 32,
   parameter bit          MASK_LO = 1'b0,
   parameter logic [HALF_W-1:0] LO_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] lo_q,
   output logic [HALF_W-1:0] hi_q
);
   localparam int unsigned FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] count_q;
   logic [HALF_W-1:0] lo_wr_val;

   generate
      if (MASK_LO) begin : g_masked
         assign lo_wr_val = wdata & LO_MASK;
         assign lo_q      = count_q[HALF_W-1:0] & LO_MASK;
      end else begin : g_plain
         assign lo_wr_val = wdata;
         assign lo_q      = count_q[HALF_W-1:0];
      end
   endgenerate

   assign hi_q = count_q[FULL_W-1:HALF_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (lo_we || hi_we) begin
         if (lo_we) count_q[HALF_W-1:0]      <= lo_wr_val;
         if (hi_we) count_q[FULL_W-1:HALF_W] <= wdata;
      end else if (tick) begin
         count_q <= count_q + {{(FULL_W-1){1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value,
   output logic         msb_rise
);
   import tbd_pkg::*;

   logic [W-1:0] val_q;
   logic [W-1:0] val_d;

   always_comb begin
      if (we)        val_d = wdata;
      else if (tick) val_d = val_q - {{(W-1){1'b0}}, 1'b1};
      else           val_d = val_q;
   end

   assign msb_rise = sign_rise(val_q[W-1], val_d[W-1]);
   assign value    = val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) val_q <= '1;
      else        val_q <= val_d;
   end
endmodule

// File: rtl/tbd_irq_flag.sv
module tbd_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (ack) flag <= 1'b0;
   end
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr #(
   parameter int unsigned HALF_W   = 32,
   parameter int unsigned DEC_W    = 32,
   parameter bit          RTC_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tb_lo_we,
   input  logic              tb_hi_we,
   input  logic              dec_we,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              irq_ack,
   output logic [HALF_W-1:0] tb_lo_rd,
   output logic [HALF_W-1:0] tb_hi_rd,
   output logic [DEC_W-1:0]  dec_rd,
   output logic              dec_irq
);
   import tbd_pkg::*;

   localparam logic [HALF_W-1:0] LO_MASK =
      RTC_MODE ? TBD_RTC_LO_MASK[HALF_W-1:0] : '1;

   generate
      if (DEC_W != HALF_W) begin : g_bad_dec_w
         $error("DEC_W must equal HALF_W");
      end
      if (RTC_MODE && HALF_W != TBD_HALF_W) begin : g_bad_rtc_w
         $error("RTC mode needs HALF_W of 32");
      end
   endgenerate

   logic rise;

   tbd_timebase #(
      .HALF_W  (HALF_W),
      .MASK_LO (RTC_MODE),
      .LO_MASK (LO_MASK)
   ) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .lo_we (tb_lo_we),
      .hi_we (tb_hi_we),
      .wdata (wr_data),
      .lo_q  (tb_lo_rd),
      .hi_q  (tb_hi_rd)
   );

   tbd_decrementer #(.W(DEC_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .we       (dec_we),
      .wdata    (wr_data[DEC_W-1:0]),
      .value    (dec_rd),
      .msb_rise (rise)
   );

   tbd_irq_flag u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (rise),
      .ack   (irq_ack),
      .flag  (dec_irq)
   );
endmodule

// File: rtl/timebase_decr_chk.sv
module timebase_decr_chk #(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned DEC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              tb_lo_we,
   input logic              tb_hi_we,
   input logic              dec_we,
   input logic [HALF_W-1:0] wr_data,
   input logic              irq_ack,
   input logic [HALF_W-1:0] tb_lo_rd,
   input logic [HALF_W-1:0] tb_hi_rd,
   input logic [DEC_W-1:0]  dec_rd,
   input logic              dec_irq
);
   AST_TB_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !tb_lo_we && !tb_hi_we) |=> ($stable(tb_hi_rd) && $stable(tb_lo_rd))); // R1
   AST_HI_WR_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_hi_we && !tb_lo_we) |=> $stable(tb_lo_rd)); // R2
   AST_DEC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dec_we) |=> (dec_rd == $past(dec_rd) - 1'b1)); // R3
   AST_DEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dec_we |=> (dec_rd == $past(wr_data[DEC_W-1:0]))); // R4
   AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !dec_we && dec_rd == '0) |=> dec_irq); // R5
   AST_NEG_WR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_we && wr_data[DEC_W-1] && !dec_rd[DEC_W-1]) |=> dec_irq); // R6
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_we && dec_rd[DEC_W-1] && !dec_irq) |=> !dec_irq); // R6
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_irq && !irq_ack) |=> dec_irq); // R7
endmodule

bind timebase_decr timebase_decr_chk #(.HALF_W(HALF_W), .DEC_W(DEC_W)) u_chk (.*);

// File: tb/timebase_decr_bench.sv
`timescale 1ns/1ps
module timebase_decr_bench;
   localparam logic [31:0] RMASK = 32'h3FFF_FF80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, tb_lo_we = 1'b0, tb_hi_we = 1'b0, dec_we = 1'b0, irq_ack = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] lo_a, hi_a, dec_a, lo_r, hi_r, dec_r;
   logic        irq_a, irq_r;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [63:0] tb_m, tbr_m;
   logic [31:0] dec_m;
   logic        irq_m;

   always #2 clk = ~clk;

   timebase_decr u_timebase_decr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tb_lo_we(tb_lo_we), .tb_hi_we(tb_hi_we),
      .dec_we(dec_we), .wr_data(wr_data), .irq_ack(irq_ack),
      .tb_lo_rd(lo_a), .tb_hi_rd(hi_a), .dec_rd(dec_a), .dec_irq(irq_a));

   timebase_decr #(.RTC_MODE(1'b1)) u_timebase_decr_rtc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tb_lo_we(tb_lo_we), .tb_hi_we(tb_hi_we),
      .dec_we(dec_we), .wr_data(wr_data), .irq_ack(irq_ack),
      .tb_lo_rd(lo_r), .tb_hi_rd(hi_r), .dec_rd(dec_r), .dec_irq(irq_r));

   function automatic logic [63:0] tb_next(input logic [63:0] cur, input logic tk,
                                           input logic lwe, input logic uwe,
                                           input logic [31:0] wd, input logic [31:0] msk);
      logic [63:0] n = cur;
      if (lwe || uwe) begin
         if (lwe) n[31:0]  = wd & msk;
         if (uwe) n[63:32] = wd;
      end else if (tk) begin
         n = cur + 64'd1;
      end
      return n;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      chk(req, "tb_lo", lo_a, tb_m[31:0]);
      chk(req, "tb_hi", hi_a, tb_m[63:32]);
      chk(req, "dec", dec_a, dec_m);
      chk(req, "irq", {31'd0, irq_a}, {31'd0, irq_m});
      chk({req, " R9"}, "rtc_lo", lo_r, tbr_m[31:0] & RMASK);
      chk({req, " R9"}, "rtc_hi", hi_r, tbr_m[63:32]);
   endtask

   // Called at a falling edge: drive, update model at the rising edge, compare at next falling edge.
   task automatic step(input logic tk, input logic lwe, input logic uwe, input logic dwe,
                       input logic ack, input logic [31:0] wd, input string req);
      logic [31:0] nd;
      tick = tk; tb_lo_we = lwe; tb_hi_we = uwe; dec_we = dwe; irq_ack = ack; wr_data = wd;
      @(posedge clk);
      tb_m  = tb_next(tb_m,  tk, lwe, uwe, wd, 32'hFFFF_FFFF);
      tbr_m = tb_next(tbr_m, tk, lwe, uwe, wd, RMASK);
      nd = dwe ? wd : (tk ? dec_m - 32'd1 : dec_m);
      if (!dec_m[31] && nd[31]) irq_m = 1'b1;
      else if (ack)             irq_m = 1'b0;
      dec_m = nd;
      @(negedge clk);
      compare_all(req);
   endtask

   initial begin
      tb_m = '0; tbr_m = '0; dec_m = 32'hFFFF_FFFF; irq_m = 1'b0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R8");

      // R1: counting and holding
      step(1, 0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, 0, "R1");
      step(1, 0, 0, 0, 0, 0, "R1");
      // R1: carry from the lower into the upper word
      step(0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R2");
      step(1, 0, 0, 0, 0, 0, "R1");
      // R2: half writes keep the other half
      step(0, 0, 1, 0, 0, 32'hDEAD_BEEF, "R2");
      step(0, 1, 0, 0, 0, 32'h1234_5678, "R2");
      step(1, 1, 1, 0, 0, 32'hC0FF_EE00, "R4");
      // R3/R5: count down through zero
      step(0, 0, 0, 1, 0, 32'd1, "R4");
      step(1, 0, 0, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 0, 0, "R5");
      step(1, 0, 0, 0, 0, 0, "R3");
      // R7: ack clears, ack plus new request keeps set
      step(0, 0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 1, 0, 32'h0000_0000, "R4");
      step(1, 0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 1, 0, "R7");
      // R6: negative write while negative gives nothing
      step(0, 0, 0, 1, 0, 32'h8000_0005, "R6");
      // R6: negative write while positive raises, write beats tick
      step(0, 0, 0, 1, 0, 32'h0000_0010, "R4");
      step(1, 0, 0, 1, 0, 32'h8000_0000, "R6");
      step(0, 0, 0, 0, 1, 0, "R7");
      // R9: masked lower word
      step(0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R9");
      step(1, 0, 0, 0, 0, 0, "R9");

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] w = $urandom;
         if ($urandom_range(1, 0) == 1) w = $urandom_range(3, 0);
         step($urandom_range(1, 0) == 1, $urandom_range(19, 0) == 0, $urandom_range(19, 0) == 0,
              $urandom_range(9, 0) == 0, $urandom_range(7, 0) == 0, w, "R3 R5 R6 R7");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule